// File: doc/BRIEF.md
# Output Compare Event Unit

This block watches a free-running 16-bit timer value and a 16-bit compare value. When the two first become equal it carries out one action chosen by a 4-bit mode code: it toggles, sets or clears an output pin, it raises only an interrupt pulse while leaving the pin to other logic, or it fires a special trigger. The special trigger asks the timer to restart and, when the converter is enabled, asks for an analog-to-digital conversion.

An equality that lasts several cycles counts as one event. The event is taken on the cycle the values become equal. When the mode changes to a set or clear code, the pin is first preset to the level opposite to the one the match will produce, so the next match always gives a visible edge. All outputs are registered. An event seen at a clock edge shows on the outputs right after that edge.

Top module: `ocmp_unit`

## Requirements
- R1: While `rst_i` is high, and right after it, `pin_o`, `pin_oe_o`, `irq_o`, `tmr_clr_o` and `adc_go_o` are all 0.
- R2: In mode 4'b0010 each event inverts `pin_o` and pulses `irq_o`.
- R3: In mode 4'b1000 an event drives `pin_o` to 1 and pulses `irq_o`.
- R4: In mode 4'b1001 an event drives `pin_o` to 0 and pulses `irq_o`.
- R5: The cycle after `mode_i` changes to 4'b1000, `pin_o` is 0. After a change to 4'b1001 it is 1. The clock edge that registers a mode change takes no match action.
- R6: In mode 4'b1010 an event pulses `irq_o` only. `pin_o` keeps its level and `pin_oe_o` is 0.
- R7: In mode 4'b1011 an event pulses `irq_o` and `tmr_clr_o`. `adc_go_o` pulses with them only when `adc_en_i` is 1.
- R8: Reserved codes 4'b0001 and 4'b0011, and every code not named in R2 to R7 or R12, produce no pulse on any output and leave `pin_o` unchanged.
- R9: An event happens only on a cycle where `timer_i == cmp_i` and the two were not equal at the previous clock edge. A held equality gives exactly one event, including at the values 0 and 16'hFFFF.
- R10: `irq_o`, `tmr_clr_o` and `adc_go_o` are never high for two cycles in a row.
- R11: `pin_oe_o` is 1 exactly when the mode registered at the previous edge is 4'b0010, 4'b1000 or 4'b1001.
- R12: Mode 4'b0000 switches the unit off and drives `pin_o` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| timer_i | input | 16 | Current timer value |
| cmp_i | input | 16 | Compare value |
| mode_i | input | 4 | Match action code |
| adc_en_i | input | 1 | Converter enabled; gates the conversion request |
| pin_o | output | 1 | Output pin level |
| pin_oe_o | output | 1 | Pin drive enable |
| irq_o | output | 1 | One-cycle interrupt pulse per event |
| tmr_clr_o | output | 1 | One-cycle timer restart request |
| adc_go_o | output | 1 | One-cycle conversion start request |

## Verification
All sixteen mode codes are swept with the converter both enabled and disabled. For each code the bench checks the preset level on mode entry, a first event, a held equality, and a second event after the equality drops. This tells toggle apart from set and clear, shows which modes drive the pin, and shows that the special trigger depends on the enable. Another sweep moves the timer across compare values at 0, 1, the midpoint and all-ones. It counts events to confirm that each crossing gives one event, including where the timer wraps. A final pattern switches from toggle to off to show that the off code forces the pin low.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

   localparam int unsigned MODE_BITS = 4;

   localparam logic [MODE_BITS-1:0] M_OFF    = 4'b0000;
   localparam logic [MODE_BITS-1:0] M_TOGGLE = 4'b0010;
   localparam logic [MODE_BITS-1:0] M_SET    = 4'b1000;
   localparam logic [MODE_BITS-1:0] M_CLEAR  = 4'b1001;
   localparam logic [MODE_BITS-1:0] M_IRQ    = 4'b1010;
   localparam logic [MODE_BITS-1:0] M_TRIG   = 4'b1011;

   typedef enum logic [2:0] {
      PA_HOLD = 3'd0,
      PA_TOG  = 3'd1,
      PA_SET  = 3'd2,
      PA_CLR  = 3'd3,
      PA_LOW  = 3'd4
   } pin_act_e;

   typedef struct packed {
      pin_act_e pin_act;
      logic     drive;
      logic     raise_irq;
      logic     trigger;
   } act_t;

   function automatic act_t decode_mode(input logic [MODE_BITS-1:0] m);
      act_t a;
      a = '{pin_act: PA_HOLD, drive: 1'b0, raise_irq: 1'b0, trigger: 1'b0};
      unique case (m)
         M_OFF:    a.pin_act = PA_LOW;
         M_TOGGLE: begin a.pin_act = PA_TOG; a.drive = 1'b1; a.raise_irq = 1'b1; end
         M_SET:    begin a.pin_act = PA_SET; a.drive = 1'b1; a.raise_irq = 1'b1; end
         M_CLEAR:  begin a.pin_act = PA_CLR; a.drive = 1'b1; a.raise_irq = 1'b1; end
         M_IRQ:    a.raise_irq = 1'b1;
         M_TRIG:   begin a.raise_irq = 1'b1; a.trigger = 1'b1; end
         default:  ;
      endcase
      return a;
   endfunction

endpackage

// File: rtl/ocmp_match.sv
module ocmp_match #(
   parameter int unsigned WIDTH    = 16,
   parameter bit          ONE_SHOT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [WIDTH-1:0] timer_i,
   input  logic [WIDTH-1:0] cmp_i,
   output logic             hit_o
);

   if (WIDTH < 2) begin : g_bad_width
      $error("ocmp_match: WIDTH must be at least 2");
   end

   logic eq;
   assign eq = (timer_i == cmp_i);

   if (ONE_SHOT) begin : g_edge
      logic eq_q;
      always_ff @(posedge clk_i) begin
         if (rst_i) eq_q <= 1'b0;
         else       eq_q <= eq;
      end
      assign hit_o = eq & ~eq_q;

      AST_HIT_ONCE: assert property (@(posedge clk_i) disable iff (rst_i)
         hit_o |=> !hit_o) else $error("hit repeated"); // R9
   end else begin : g_level
      assign hit_o = eq;
   end

endmodule

// File: rtl/ocmp_pin.sv
module ocmp_pin
   import ocmp_pkg::*;
(
   input  logic clk_i,
   input  logic rst_i,
   input  act_t act_i,
   input  logic entry_i,
   input  logic hit_i,
   output logic pin_o,
   output logic oe_o
);

   logic pin_d;

   always_comb begin
      pin_d = pin_o;
      if (act_i.pin_act == PA_LOW) begin
         pin_d = 1'b0;
      end else if (entry_i) begin
         if (act_i.pin_act == PA_SET)      pin_d = 1'b0;
         else if (act_i.pin_act == PA_CLR) pin_d = 1'b1;
      end else if (hit_i) begin
         case (act_i.pin_act)
            PA_TOG:  pin_d = ~pin_o;
            PA_SET:  pin_d = 1'b1;
            PA_CLR:  pin_d = 1'b0;
            default: pin_d = pin_o;
         endcase
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pin_o <= 1'b0;
         oe_o  <= 1'b0;
      end else begin
         pin_o <= pin_d;
         oe_o  <= act_i.drive;
      end
   end

   AST_SET_HIGH: assert property (@(posedge clk_i) disable iff (rst_i)
      (hit_i && !entry_i && act_i.pin_act == PA_SET) |=> pin_o) else $error("set"); // R3
   AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (hit_i && !entry_i && act_i.pin_act == PA_CLR) |=> !pin_o) else $error("clear"); // R4
   AST_TOGGLE_FLIP: assert property (@(posedge clk_i) disable iff (rst_i)
      (hit_i && !entry_i && act_i.pin_act == PA_TOG) |=> (pin_o != $past(pin_o))) else $error("toggle"); // R2
   AST_ENTRY_PRESET: assert property (@(posedge clk_i) disable iff (rst_i)
      (entry_i && act_i.pin_act == PA_SET) |=> !pin_o) else $error("preset"); // R5
   AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (rst_i)
      (act_i.pin_act == PA_LOW) |=> !pin_o) else $error("off"); // R12

endmodule

// File: rtl/ocmp_events.sv
module ocmp_events
   import ocmp_pkg::*;
#(
   parameter bit GATE_ADC = 1'b1
) (
   input  logic clk_i,
   input  logic rst_i,
   input  act_t act_i,
   input  logic hit_i,
   input  logic adc_en_i,
   output logic irq_o,
   output logic tmr_clr_o,
   output logic adc_go_o
);

   logic adc_ok;

   if (GATE_ADC) begin : g_gated
      assign adc_ok = adc_en_i;
   end else begin : g_free
      assign adc_ok = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         irq_o     <= 1'b0;
         tmr_clr_o <= 1'b0;
         adc_go_o  <= 1'b0;
      end else begin
         irq_o     <= hit_i & act_i.raise_irq;
         tmr_clr_o <= hit_i & act_i.trigger;
         adc_go_o  <= hit_i & act_i.trigger & adc_ok;
      end
   end

   AST_IRQ_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_o |=> !irq_o) else $error("irq width"); // R10
   AST_CLR_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      tmr_clr_o |=> !tmr_clr_o) else $error("clr width"); // R10
   AST_ADC_WITH_CLR: assert property (@(posedge clk_i) disable iff (rst_i)
      adc_go_o |-> (tmr_clr_o && irq_o)) else $error("adc alone"); // R7

endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
   import ocmp_pkg::*;
#(
   parameter int unsigned TMR_W    = 16,
   parameter int unsigned MODE_W   = 4,
   parameter bit          ONE_SHOT = 1'b1,
   parameter bit          GATE_ADC = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [TMR_W-1:0]  timer_i,
   input  logic [TMR_W-1:0]  cmp_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic              adc_en_i,
   output logic              pin_o,
   output logic              pin_oe_o,
   output logic              irq_o,
   output logic              tmr_clr_o,
   output logic              adc_go_o
);

   if (MODE_W != MODE_BITS) begin : g_bad_mode
      $error("ocmp_unit: MODE_W must equal the package mode width");
   end

   logic [MODE_W-1:0] mode_q;
   logic              entry;
   logic              hit_raw;
   logic              hit_ok;
   act_t              act;

   always_ff @(posedge clk_i) begin
      if (rst_i) mode_q <= M_OFF;
      else       mode_q <= mode_i;
   end

   assign entry  = (mode_i != mode_q);
   assign act    = decode_mode(mode_i);
   assign hit_ok = hit_raw & ~entry;

   ocmp_match #(.WIDTH(TMR_W), .ONE_SHOT(ONE_SHOT)) u_match (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .timer_i (timer_i),
      .cmp_i   (cmp_i),
      .hit_o   (hit_raw)
   );

   ocmp_pin u_pin (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .act_i   (act),
      .entry_i (entry),
      .hit_i   (hit_ok),
      .pin_o   (pin_o),
      .oe_o    (pin_oe_o)
   );

   ocmp_events #(.GATE_ADC(GATE_ADC)) u_events (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .act_i     (act),
      .hit_i     (hit_ok),
      .adc_en_i  (adc_en_i),
      .irq_o     (irq_o),
      .tmr_clr_o (tmr_clr_o),
      .adc_go_o  (adc_go_o)
   );

   AST_RESERVED_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == 4'b0001 || mode_i == 4'b0011) |=> !(irq_o || tmr_clr_o || adc_go_o)) else $error("reserved"); // R8
   AST_IRQ_MODE_PIN_FREE: assert property (@(posedge clk_i) disable iff (rst_i)
      (mode_i == M_IRQ) |=> (!pin_oe_o && $stable(pin_o))) else $error("irq mode pin"); // R6
   AST_OE_MODES: assert property (@(posedge clk_i) disable iff (rst_i)
      1'b1 |=> (pin_oe_o == ($past(mode_i) == M_TOGGLE || $past(mode_i) == M_SET || $past(mode_i) == M_CLEAR))) else $error("oe"); // R11

endmodule

// File: tb/tb_ocmp_unit.sv
module tb_ocmp_unit;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] timer, cmp;
   logic [3:0]  mode;
   logic        adc_en;
   logic        pin, oe, irq, tclr, adc;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   ocmp_unit dut (
      .clk_i(clk), .rst_i(rst), .timer_i(timer), .cmp_i(cmp), .mode_i(mode),
      .adc_en_i(adc_en), .pin_o(pin), .pin_oe_o(oe), .irq_o(irq),
      .tmr_clr_o(tclr), .adc_go_o(adc)
   );

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   function automatic bit drives(input int m);
      return (m == 2 || m == 8 || m == 9);
   endfunction

   function automatic bit raises(input int m);
      return (m == 2 || m == 8 || m == 9 || m == 10 || m == 11);
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int evs;
      bit exp_pin;
      rst = 1'b1; timer = 16'd5; cmp = 16'd9; mode = 4'd0; adc_en = 1'b0;
      step(); step();
      chk("R1 pin", pin, 0); chk("R1 oe", oe, 0); chk("R1 irq", irq, 0);
      chk("R1 tclr", tclr, 0); chk("R1 adc", adc, 0);

      for (int m = 0; m < 16; m++) begin
         for (int a = 0; a < 2; a++) begin
            rst = 1'b1; mode = 4'd0; timer = 16'd5; cmp = 16'd9; adc_en = a[0];
            step(); step();
            rst = 1'b0;
            step();
            chk("R1 after reset irq", irq, 0);
            // mode entry: preset R5, drive enable R11
            mode = m[3:0];
            step();
            exp_pin = (m == 9);
            chk("R5 preset", pin, exp_pin);
            chk("R11 oe", oe, drives(m));
            chk("R8 entry quiet", irq | tclr | adc, 0);
            // first event
            timer = 16'd9;
            step();
            if (m == 2 || m == 8) exp_pin = 1'b1;
            if (m == 9) exp_pin = 1'b0;
            chk("R2/R3/R4/R6/R8 pin", pin, exp_pin);
            chk("R2/R3/R4/R6/R7/R8 irq", irq, raises(m));
            chk("R7 tclr", tclr, (m == 11));
            chk("R7 adc", adc, (m == 11) && a == 1);
            chk("R6 R11 oe", oe, drives(m));
            // held equality
            step();
            chk("R9 R10 hold", irq | tclr | adc, 0);
            chk("R9 hold pin", pin, exp_pin);
            // drop then second event
            timer = 16'd10; step();
            timer = 16'd9;  step();
            if (m == 2) exp_pin = 1'b0;
            chk("R2 R9 second pin", pin, exp_pin);
            chk("R9 second irq", irq, raises(m));
            timer = 16'd10; step();
            chk("R10 pulses end", irq | tclr | adc, 0);
         end
      end

      // R12: off forces pin low after toggle drove it high
      rst = 1'b1; mode = 4'd0; timer = 16'd1; cmp = 16'd2; step(); rst = 1'b0;
      mode = 4'd2; step();
      timer = 16'd2; step();
      chk("R12 pre toggle pin", pin, 1);
      mode = 4'd0; step();
      chk("R12 off pin", pin, 0);
      chk("R12 off oe", oe, 0);

      // R9: crossings at boundary compare values, including wrap
      foreach (cmp_list[i]) begin
         rst = 1'b1; mode = 4'd0; cmp = cmp_list[i]; timer = cmp_list[i] - 16'd3;
         step(); rst = 1'b0;
         mode = 4'd2; step();
         evs = 0;
         for (int k = 0; k < 7; k++) begin
            timer = cmp_list[i] - 16'd3 + 16'(k);
            step();
            evs += irq;
         end
         step(); evs += irq;
         chk("R9 one event per crossing", evs, 1);
         chk("R2 crossing pin", pin, 1);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   logic [15:0] cmp_list [4] = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};

endmodule